// File: doc/BRIEF.md
# Weighted Two-Source Pixel Mixer

This block blends two pixel streams into one. Each clock it takes a pixel from stream A, a pixel from stream B and a mix factor k. It produces twice the weighted sum A·k + B·(1−k) as a 13-bit result. The mix factor is a 12-bit unsigned fixed-point number with one integer bit and eleven fraction bits. Any code at or above 1.0 is clamped to exactly 1.0. The mix factor has its own load strobe. While the strobe is low, the last captured factor is reused, so a static fade needs no new factor on every pixel.

Both pixels share one number format, chosen per sample by a format select: 1 means unsigned and 0 means two's complement. The select rides down the pipeline beside its own sample, so a format change never alters results already in flight. A saturation stage sits at the end of the pipeline. It clamps the result to the limits of the active format and raises an overflow flag. Because the weights always sum to one, legal inputs should never trip it. The result, its format flag and the overflow flag leave the block six registers after capture.

Top module: `pixel_mix_top`

## Requirements
- R1: A mix code whose top bit is 1 (0x800 to 0xFFF) behaves exactly like 0x800, which is the value 1.0. Codes below 0x800 are the value code/2048.
- R2: With clamped factor kc, the result equals floor((A·kc + B·(2048−kc)) / 1024), taken as a 13-bit pattern. Rounding is toward minus infinity, so a small negative sum gives all ones.
- R3: Mix code 0 yields 2·B, code 0x800 yields 2·A, and code 0x400 yields exactly A+B.
- R4: When fmt_unsigned is 1, both pixels are read as unsigned 0..4095. When it is 0, both are read as two's complement −2048..2047, and the result is a 13-bit two's-complement value.
- R5: When mix_load is 1, mix_k is captured on the rising edge and is used by the pixels captured on that same edge. When mix_load is 0, mix_k is ignored and the stored factor is used.
- R6: A sample presented before rising edge n appears on mix_out after rising edge n+5 and stays there for one cycle. That is six register stages, with a new result every cycle.
- R7: out_unsigned reports the format select of the sample currently on mix_out. Changing the select between back-to-back samples changes only the samples captured after the change.
- R8: The final stage clamps to 0..8191 for unsigned or −4096..4095 for signed, and raises out_ovf for a clamped sample. For all legal inputs, including full-scale extremes, no clamping occurs and out_ovf stays 0.
- R9: Reset is synchronous and active low. It clears every pipeline stage and sets the stored factor to 0, so mix_out, out_unsigned and out_ovf read 0. A sample sent after reset with mix_load low then yields 2·B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_a | input | 12 | Pixel of stream A, weighted by k |
| pix_b | input | 12 | Pixel of stream B, weighted by 1−k |
| mix_k | input | 12 | Mix factor, unsigned with one integer bit |
| mix_load | input | 1 | 1 captures mix_k, 0 keeps the stored factor |
| fmt_unsigned | input | 1 | Pixel format: 1 unsigned, 0 two's complement |
| mix_out | output | 13 | Twice the weighted sum |
| out_unsigned | output | 1 | Format select of the sample on mix_out |
| out_ovf | output | 1 | Result of this sample was clamped |

## Verification
The bench checks every output cycle against its own model. This catches a pipeline one stage short or long, and a format flag that is taken from the current input instead of travelling with its sample. Mix codes above 0x800 are driven to catch a design that uses the raw code and scales A past 1.0. A held factor is tested while mix_k changes freely, to catch a register that ignores the load strobe. Full-scale signed and unsigned extremes would expose a saturation stage that clips legal values. A negative sum just below zero would expose a result that rounds toward zero instead of down.

// File: rtl/pixel_mix_pkg.sv
package pixel_mix_pkg;
  typedef enum logic {
    FMT_TWOS = 1'b0,
    FMT_UNS  = 1'b1
  } pix_fmt_e;
endpackage

// File: rtl/pixel_mix_front.sv
module pixel_mix_front
  import pixel_mix_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int MIX_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PIX_W-1:0]        pix_a,
  input  logic [PIX_W-1:0]        pix_b,
  input  logic [MIX_W-1:0]        mix_k,
  input  logic                    mix_load,
  input  pix_fmt_e                fmt_in,
  output logic signed [PIX_W:0]   a_ext,
  output logic signed [PIX_W:0]   b_ext,
  output logic [MIX_W-1:0]        w_a,
  output logic [MIX_W-1:0]        w_b,
  output pix_fmt_e                fmt_out
);
  localparam logic [MIX_W-1:0] MIX_ONE = {1'b1, {(MIX_W-1){1'b0}}};

  function automatic logic [MIX_W-1:0] clamp_mix(input logic [MIX_W-1:0] m);
    return m[MIX_W-1] ? MIX_ONE : m;
  endfunction

  function automatic logic signed [PIX_W:0] widen_pix(input logic [PIX_W-1:0] p,
                                                       input pix_fmt_e f);
    return (f == FMT_UNS) ? {1'b0, p} : {p[PIX_W-1], p};
  endfunction

  // stage 1: capture pixels and format, mix register with load strobe
  logic [PIX_W-1:0] a_q, b_q;
  logic [MIX_W-1:0] m_q;
  pix_fmt_e         fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      m_q   <= '0;
      fmt_q <= FMT_TWOS;
    end else begin
      a_q   <= pix_a;
      b_q   <= pix_b;
      fmt_q <= fmt_in;
      if (mix_load) m_q <= mix_k;
    end
  end

  // stage 2: format conversion and weight pair
  logic [MIX_W-1:0] m_clamped;
  assign m_clamped = clamp_mix(m_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ext   <= '0;
      b_ext   <= '0;
      w_a     <= '0;
      w_b     <= MIX_ONE;
      fmt_out <= FMT_TWOS;
    end else begin
      a_ext   <= widen_pix(a_q, fmt_q);
      b_ext   <= widen_pix(b_q, fmt_q);
      w_a     <= m_clamped;
      w_b     <= MIX_ONE - m_clamped;
      fmt_out <= fmt_q;
    end
  end

  p_mix_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mix_load |=> (m_q == $past(mix_k)));
  p_mix_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mix_load |=> $stable(m_q));
  p_weight_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_a <= MIX_ONE) && ({1'b0, w_a} + {1'b0, w_b} == {1'b0, MIX_ONE})));
endmodule

// File: rtl/pixel_mix_mac.sv
module pixel_mix_mac
  import pixel_mix_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int MIX_W = 12,
  localparam int PROD_W = PIX_W + MIX_W + 2,
  localparam int SUM_W  = PROD_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [PIX_W:0]    a_ext,
  input  logic signed [PIX_W:0]    b_ext,
  input  logic [MIX_W-1:0]         w_a,
  input  logic [MIX_W-1:0]         w_b,
  input  pix_fmt_e                 fmt_in,
  output logic signed [SUM_W-1:0]  sum_q,
  output pix_fmt_e                 fmt_out
);
  function automatic logic signed [PROD_W-1:0] weigh(input logic signed [PIX_W:0] p,
                                                      input logic [MIX_W-1:0] w);
    logic signed [MIX_W:0] ws;
    ws = $signed({1'b0, w});
    return PROD_W'(p) * PROD_W'(ws);
  endfunction

  logic signed [PROD_W-1:0] prod_a, prod_b;
  pix_fmt_e fmt3;

  // stage 3: products
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_a <= '0;
      prod_b <= '0;
      fmt3   <= FMT_TWOS;
    end else begin
      prod_a <= weigh(a_ext, w_a);
      prod_b <= weigh(b_ext, w_b);
      fmt3   <= fmt_in;
    end
  end

  // stage 4: sum
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q   <= '0;
      fmt_out <= FMT_TWOS;
    end else begin
      sum_q   <= SUM_W'(prod_a) + SUM_W'(prod_b);
      fmt_out <= fmt3;
    end
  end

  p_zero_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_a == '0) |=> (prod_a == '0));
endmodule

// File: rtl/pixel_mix_back.sv
module pixel_mix_back
  import pixel_mix_pkg::*;
#(
  parameter int MIX_W = 12,
  parameter int OUT_W = 13,
  parameter int SUM_W = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SUM_W-1:0] sum_in,
  input  pix_fmt_e                fmt_in,
  output logic [OUT_W-1:0]        res_q,
  output logic                    ovf_q,
  output pix_fmt_e                fmt_out
);
  localparam int SHIFT = MIX_W - 2;
  localparam logic signed [SUM_W-1:0] U_MAX = SUM_W'((1 << OUT_W) - 1);
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = -SUM_W'(1 << (OUT_W-1));

  function automatic logic signed [SUM_W-1:0] scale_sum(input logic signed [SUM_W-1:0] s);
    return s >>> SHIFT;
  endfunction

  function automatic logic [OUT_W:0] clip(input logic signed [SUM_W-1:0] v,
                                          input pix_fmt_e f);
    logic signed [SUM_W-1:0] lo, hi;
    lo = (f == FMT_UNS) ? '0 : S_MIN;
    hi = (f == FMT_UNS) ? U_MAX : S_MAX;
    if (v > hi)      return {1'b1, hi[OUT_W-1:0]};
    else if (v < lo) return {1'b1, lo[OUT_W-1:0]};
    else             return {1'b0, v[OUT_W-1:0]};
  endfunction

  logic signed [SUM_W-1:0] scaled_q;
  pix_fmt_e fmt5;
  logic [OUT_W:0] clipped;

  // stage 5: fixed doubling and fraction removal
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scaled_q <= '0;
      fmt5     <= FMT_TWOS;
    end else begin
      scaled_q <= scale_sum(sum_in);
      fmt5     <= fmt_in;
    end
  end

  assign clipped = clip(scaled_q, fmt5);

  // stage 6: saturation and output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      ovf_q   <= 1'b0;
      fmt_out <= FMT_TWOS;
    end else begin
      res_q   <= clipped[OUT_W-1:0];
      ovf_q   <= clipped[OUT_W];
      fmt_out <= fmt5;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n) !ovf_q);
  p_uns_scaled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt5 == FMT_UNS) |-> (scaled_q >= 0));
endmodule

// File: rtl/pixel_mix_top.sv
module pixel_mix_top
  import pixel_mix_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int MIX_W = 12,
  parameter int OUT_W = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic [MIX_W-1:0] mix_k,
  input  logic             mix_load,
  input  logic             fmt_unsigned,
  output logic [OUT_W-1:0] mix_out,
  output logic             out_unsigned,
  output logic             out_ovf
);
  localparam int SUM_W = PIX_W + MIX_W + 3;

  logic signed [PIX_W:0]   a_ext, b_ext;
  logic [MIX_W-1:0]        w_a, w_b;
  logic signed [SUM_W-1:0] sum;
  pix_fmt_e                fmt2, fmt4, fmt6;

  pixel_mix_front #(.PIX_W(PIX_W), .MIX_W(MIX_W)) u_front (
    .clk(clk), .rst_n(rst_n), .pix_a(pix_a), .pix_b(pix_b), .mix_k(mix_k),
    .mix_load(mix_load), .fmt_in(pix_fmt_e'(fmt_unsigned)),
    .a_ext(a_ext), .b_ext(b_ext), .w_a(w_a), .w_b(w_b), .fmt_out(fmt2));

  pixel_mix_mac #(.PIX_W(PIX_W), .MIX_W(MIX_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .a_ext(a_ext), .b_ext(b_ext), .w_a(w_a), .w_b(w_b),
    .fmt_in(fmt2), .sum_q(sum), .fmt_out(fmt4));

  pixel_mix_back #(.MIX_W(MIX_W), .OUT_W(OUT_W), .SUM_W(SUM_W)) u_back (
    .clk(clk), .rst_n(rst_n), .sum_in(sum), .fmt_in(fmt4),
    .res_q(mix_out), .ovf_q(out_ovf), .fmt_out(fmt6));

  assign out_unsigned = (fmt6 == FMT_UNS);
endmodule

// File: tb/sim_pixel_mix_top.sv
module sim_pixel_mix_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pix_a = '0, pix_b = '0, mix_k = '0;
  logic        mix_load = 1'b0, fmt_unsigned = 1'b0;
  logic [12:0] mix_out;
  logic        out_unsigned, out_ovf;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  int    exp_q [8];
  bit    uns_q [8];
  string tag_q [8];
  int    n = 0;
  int    m_held = 0;

  always #5 clk = ~clk;

  pixel_mix_top u0 (.clk(clk), .rst_n(rst_n), .pix_a(pix_a), .pix_b(pix_b),
    .mix_k(mix_k), .mix_load(mix_load), .fmt_unsigned(fmt_unsigned),
    .mix_out(mix_out), .out_unsigned(out_unsigned), .out_ovf(out_ovf));

  function automatic int model(int a, int b, int m, bit uns);
    int av, bv, kc, e, q;
    av = uns ? a : (a >= 2048 ? a - 4096 : a);
    bv = uns ? b : (b >= 2048 ? b - 4096 : b);
    kc = (m >= 2048) ? 2048 : m;
    e  = av * kc + bv * (2048 - kc);
    if (e >= 0) q = e / 1024;
    else        q = -((-e + 1023) / 1024);
    return q & 32'h1FFF;
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // one cycle: verify the sample issued six cycles ago, then present a new one
  task automatic push(input int a, input int b, input int m, input bit ld,
                      input bit uns, input string req);
    int k;
    @(negedge clk);
    if (n >= 6) begin
      k = (n - 6) % 8;
      check(tag_q[k], (int'(mix_out) == exp_q[k]) && (out_unsigned == uns_q[k]) && !out_ovf,
            {19'd0, out_ovf, out_unsigned, mix_out}, {19'd0, 1'b0, uns_q[k], exp_q[k][12:0]});
    end
    pix_a = 12'(a); pix_b = 12'(b); mix_k = 12'(m);
    mix_load = ld; fmt_unsigned = uns;
    if (ld) m_held = m;
    exp_q[n % 8] = model(a, b, m_held, uns);
    uns_q[n % 8] = uns;
    tag_q[n % 8] = req;
    n++;
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) push(0, 0, 0, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; mix_load = 1'b1; mix_k = 12'h555; pix_a = 12'h123; pix_b = 12'h321;
    repeat (3) @(negedge clk);
    check("R9", (mix_out == 13'd0) && !out_unsigned && !out_ovf,
          {19'd0, out_ovf, out_unsigned, mix_out}, 0);
    rst_n = 1'b1; mix_load = 1'b0;
    n = 0; m_held = 0;
    // stored factor is 0 after reset, mix_k ignored: expect 2*B
    push(100, 300, 12'hFFF, 1'b0, 1'b1, "R9");
    flush();
  endtask

  task automatic t_pass();
    push(1000, 3000, 12'h000, 1'b1, 1'b1, "R3");
    push(1000, 3000, 12'h800, 1'b1, 1'b1, "R3");
    push(1000, 3000, 12'h400, 1'b1, 1'b1, "R3");
    push(4095, 1,    12'h400, 1'b1, 1'b1, "R3");
    flush();
  endtask

  task automatic t_clamp();
    push(2500, 700, 12'h801, 1'b1, 1'b1, "R1");
    push(2500, 700, 12'hABC, 1'b1, 1'b1, "R1");
    push(2500, 700, 12'hFFF, 1'b1, 1'b1, "R1");
    push(2500, 700, 12'h7FF, 1'b1, 1'b1, "R1");
    flush();
  endtask

  task automatic t_arith();
    push(12'hF00, 12'h0FF, 12'h2AB, 1'b1, 1'b0, "R4");
    push(12'hF00, 12'h0FF, 12'h2AB, 1'b1, 1'b1, "R4");
    push(1, 0, 1, 1'b1, 1'b1, "R2");
    push(12'hFFF, 0, 1, 1'b1, 1'b0, "R2");
    push(1234, 987, 12'h3C7, 1'b1, 1'b1, "R2");
    push(12'h9A5, 12'h3F1, 12'h5E2, 1'b1, 1'b0, "R2");
    flush();
  endtask

  task automatic t_hold();
    push(800, 200, 12'h200, 1'b1, 1'b1, "R5");
    push(800, 200, 12'h7FF, 1'b0, 1'b1, "R5");
    push(900, 100, 12'h000, 1'b0, 1'b1, "R5");
    push(900, 100, 12'h600, 1'b1, 1'b1, "R5");
    push(900, 100, 12'h100, 1'b0, 1'b1, "R5");
    flush();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 10; i++)
      push(i * 311 % 4096, i * 977 % 4096, i * 201 % 4096, 1'b1, bit'(i % 2), "R7");
    push(77, 55, 12'h123, 1'b1, 1'b1, "R6");
    flush();
  endtask

  task automatic t_extremes();
    push(4095, 4095, 12'h400, 1'b1, 1'b1, "R8");
    push(4095, 4095, 12'h800, 1'b1, 1'b1, "R8");
    push(2048, 2048, 12'h400, 1'b1, 1'b0, "R8");
    push(2047, 2047, 12'h000, 1'b1, 1'b0, "R8");
    push(2048, 2047, 12'h800, 1'b1, 1'b0, "R8");
    push(0, 0, 12'h400, 1'b1, 1'b1, "R8");
    flush();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_clamp();
    t_arith();
    t_hold();
    t_stream();
    t_extremes();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule